// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16550-style serial port reports. It collects the raw event conditions of the port: receive line errors, received data at or above the FIFO trigger, character timeout, transmit holding register empty, modem input changes, and a write to the line control register while the port is busy. It masks the first five with the per-source enable bits and drives a single interrupt request line together with an 8-bit identification value that software reads to find the most urgent pending source.

Each source is cleared by the side effect that software's service routine naturally performs. Reading the line status clears line errors. Reading a character clears a timeout. Writing the holding register, or reading the identification value while it reports transmit empty, clears the transmit source. Reading the modem status clears modem changes. Reading the port status register clears busy detect. The receive-data source is a level and follows the FIFO trigger comparison directly. The data path, FIFOs, serializer, baud generator and bus decoding are outside this block and appear only as strobes and levels.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no event applied, `iir_o` reads 8'h01 and `irq_o` is low.
- R2: `iir_o[3:0]` carries the identification code: 6 line status, 4 received data, 12 character timeout, 2 transmit empty, 0 modem status, 7 busy detect, 1 nothing pending. `irq_o` is high exactly when that code is not 1.
- R3: `iir_o[7:6]` read 2'b11 while `fifo_en_i` is high and 2'b00 otherwise. `iir_o[5:4]` always read 0.
- R4: A pulse on any bit of `line_err_i` (bit 3 break, bit 2 framing, bit 1 parity, bit 0 overrun) is held. It is reported as code 6 from the next cycle while enable bit 2 is set, and is cleared by `lsr_rd_i`.
- R5: While `rx_trig_i` is high and enable bit 0 is set, code 4 is reported in the same cycle. It is withdrawn as soon as `rx_trig_i` falls.
- R6: A pulse on `rx_tmo_i` is held and reported as code 12 while enable bit 0 is set and `rx_trig_i` is low. It is cleared by `rbr_rd_i`.
- R7: The transmit-empty source is set when `thr_empty_i` rises, or when enable bit 1 rises while `thr_empty_i` is high. It is reported as code 2 while enable bit 1 is set. It is cleared by `thr_wr_i`, or by `iir_rd_i` in a cycle in which code 2 is being reported. A read that reports another code leaves it set.
- R8: A pulse on any bit of `modem_delta_i` is held and reported as code 0 while enable bit 3 is set. It is cleared by `msr_rd_i`.
- R9: `lcr_wr_i` while `uart_busy_i` is high sets busy detect, reported as code 7 regardless of the enable bits and cleared only by `usr_rd_i`. `lcr_wr_i` while `uart_busy_i` is low has no effect.
- R10: Priority from highest to lowest is line status, received data, character timeout, transmit empty, modem status, busy detect.
- R11: Enable bits 7 to 4 have no effect on `iir_o` or `irq_o`.
- R12: Clearing an enable bit hides its held source without clearing it. Setting the bit again reports the source in the same cycle.
- R13: A new event arriving in the same cycle as the clear of its source leaves the source set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en_i | input | 1 | FIFOs enabled; drives `iir_o[7:6]` |
| ier_i | input | IER_W (8) | Interrupt enable bits: 0 receive, 1 transmit empty, 2 line status, 3 modem |
| line_err_i | input | ERR_W (4) | Line error strobes: 3 break, 2 framing, 1 parity, 0 overrun |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rx_trig_i | input | 1 | Receive FIFO level at or above the trigger (level) |
| rx_tmo_i | input | 1 | Character timeout detected (strobe) |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| modem_delta_i | input | MSR_W (4) | Modem input change strobes |
| msr_rd_i | input | 1 | Modem status register read strobe |
| lcr_wr_i | input | 1 | Line control register write strobe |
| uart_busy_i | input | 1 | Port busy (level) |
| usr_rd_i | input | 1 | Port status register read strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification value |

## Verification
The bench builds the block with its default parameters: an 8-bit enable word, four line-error strobes and four modem-change strobes. Every strobe bit can therefore be pulsed on its own and shown to latch its source. The upper enable nibble is wide enough to prove that it is ignored. With all six sources pending at once, the bench peels them off one clear at a time, which walks the full priority chain. Same-cycle set and clear collisions, and the identification read that does or does not acknowledge transmit empty, are driven on purpose.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  localparam int IE_RX    = 0;
  localparam int IE_THRE  = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'd0,
    ID_NONE    = 4'd1,
    ID_THRE    = 4'd2,
    ID_RXDATA  = 4'd4,
    ID_LINE    = 4'd6,
    ID_BUSY    = 4'd7,
    ID_TIMEOUT = 4'd12
  } iid_e;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic timeout;
    logic thre;
    logic modem;
    logic busy;
  } irq_pend_t;

  // Highest pending source wins.
  function automatic iid_e pick_id(irq_pend_t p);
    iid_e id;
    if (p.line)         id = ID_LINE;
    else if (p.rxdata)  id = ID_RXDATA;
    else if (p.timeout) id = ID_TIMEOUT;
    else if (p.thre)    id = ID_THRE;
    else if (p.modem)   id = ID_MODEM;
    else if (p.busy)    id = ID_BUSY;
    else                id = ID_NONE;
    return id;
  endfunction

  function automatic logic [7:0] pack_iir(iid_e id, logic fifo_en);
    return {{2{fifo_en}}, 2'b00, id};
  endfunction

  function automatic logic irq_of(iid_e id);
    return id != ID_NONE;
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
`timescale 1ns/1ps
module uart_irq_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)        q_r[i] <= 1'b0;
        else if (set_i[i]) q_r[i] <= 1'b1;
        else if (clr_i)    q_r[i] <= 1'b0;
      end
    end
  endgenerate

  assign q_o = q_r;

  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i[0] && clr_i) |=> q_o[0]);

endmodule

// File: rtl/uart_irq_thre.sv
`timescale 1ns/1ps
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty_i,
  input  logic enable_i,
  input  logic thr_wr_i,
  input  logic ack_i,
  output logic pend_o
);

  logic empty_q, en_q, pend_q;
  logic set_w, clr_w;

  assign set_w = (thr_empty_i && !empty_q) || (enable_i && !en_q && thr_empty_i);
  assign clr_w = thr_wr_i || ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty_i;
      en_q    <= enable_i;
      if (set_w)      pend_q <= 1'b1;
      else if (clr_w) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R7
  thre_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_w) |=> !pend_o);

endmodule

// File: rtl/uart_irq_sources.sv
`timescale 1ns/1ps
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int IER_W = 8,
  parameter int ERR_W = 4,
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IER_W-1:0] ier_i,
  input  logic [ERR_W-1:0] line_err_i,
  input  logic             lsr_rd_i,
  input  logic             rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             rbr_rd_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             thre_ack_i,
  input  logic [MSR_W-1:0] modem_delta_i,
  input  logic             msr_rd_i,
  input  logic             lcr_wr_i,
  input  logic             uart_busy_i,
  input  logic             usr_rd_i,
  output irq_pend_t        pend_o
);

  logic [ERR_W-1:0] err_q;
  logic [MSR_W-1:0] modem_q;
  logic             tmo_q;
  logic             busy_q;
  logic             thre_q;
  logic             busy_set_w;

  assign busy_set_w = lcr_wr_i && uart_busy_i;

  uart_irq_sticky #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .set_i(line_err_i), .clr_i(lsr_rd_i), .q_o(err_q));

  uart_irq_sticky #(.W(MSR_W)) u_modem (
    .clk(clk), .rst_n(rst_n), .set_i(modem_delta_i), .clr_i(msr_rd_i), .q_o(modem_q));

  uart_irq_sticky #(.W(1)) u_tmo (
    .clk(clk), .rst_n(rst_n), .set_i(rx_tmo_i), .clr_i(rbr_rd_i), .q_o(tmo_q));

  uart_irq_sticky #(.W(1)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_i(busy_set_w), .clr_i(usr_rd_i), .q_o(busy_q));

  uart_irq_thre u_thre (
    .clk(clk), .rst_n(rst_n), .thr_empty_i(thr_empty_i), .enable_i(ier_i[IE_THRE]),
    .thr_wr_i(thr_wr_i), .ack_i(thre_ack_i), .pend_o(thre_q));

  always_comb begin
    pend_o.line    = (|err_q) && ier_i[IE_LINE];
    pend_o.rxdata  = rx_trig_i && ier_i[IE_RX];
    pend_o.timeout = tmo_q && ier_i[IE_RX];
    pend_o.thre    = thre_q && ier_i[IE_THRE];
    pend_o.modem   = (|modem_q) && ier_i[IE_MODEM];
    pend_o.busy    = busy_q;
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !usr_rd_i) |=> busy_q);

  // R8
  modem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_i && !(|modem_delta_i)) |=> !(|modem_q));

endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  irq_pend_t  pend_i,
  input  logic       fifo_en_i,
  output iid_e       id_o,
  output logic [7:0] iir_o,
  output logic       irq_o
);

  always_comb begin
    id_o  = pick_id(pend_i);
    iir_o = pack_iir(id_o, fifo_en_i);
    irq_o = irq_of(id_o);
  end

endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int IER_W = 8,
  parameter int ERR_W = 4,
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en_i,
  input  logic [IER_W-1:0] ier_i,
  input  logic [ERR_W-1:0] line_err_i,
  input  logic             lsr_rd_i,
  input  logic             rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             rbr_rd_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic [MSR_W-1:0] modem_delta_i,
  input  logic             msr_rd_i,
  input  logic             lcr_wr_i,
  input  logic             uart_busy_i,
  input  logic             usr_rd_i,
  output logic             irq_o,
  output logic [7:0]       iir_o
);

  irq_pend_t pend_w;
  iid_e      id_w;
  logic      thre_ack_w;
  logic      past_ok_q;

  // Acknowledge transmit empty only when the read actually reports it.
  assign thre_ack_w = iir_rd_i && (id_w == ID_THRE);

  uart_irq_sources #(.IER_W(IER_W), .ERR_W(ERR_W), .MSR_W(MSR_W)) u_src (
    .clk(clk), .rst_n(rst_n), .ier_i(ier_i),
    .line_err_i(line_err_i), .lsr_rd_i(lsr_rd_i),
    .rx_trig_i(rx_trig_i), .rx_tmo_i(rx_tmo_i), .rbr_rd_i(rbr_rd_i),
    .thr_empty_i(thr_empty_i), .thr_wr_i(thr_wr_i), .thre_ack_i(thre_ack_w),
    .modem_delta_i(modem_delta_i), .msr_rd_i(msr_rd_i),
    .lcr_wr_i(lcr_wr_i), .uart_busy_i(uart_busy_i), .usr_rd_i(usr_rd_i),
    .pend_o(pend_w));

  uart_irq_prio u_prio (
    .pend_i(pend_w), .fifo_en_i(fifo_en_i),
    .id_o(id_w), .iir_o(iir_o), .irq_o(irq_o));

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R4
  line_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && ier_i[IE_LINE] && $past(|line_err_i)) |-> (iir_o[3:0] == 4'd6));

  // R10
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w.line |-> (iir_o[3:0] == 4'd6));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ier_i[3:0] == 4'd0) && !pend_w.busy) |-> !irq_o);

endmodule

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [7:0] ier = 8'h00;
  logic [3:0] err = 4'h0;
  logic       lsr_rd = 1'b0, rx_trig = 1'b0, rx_tmo = 1'b0, rbr_rd = 1'b0;
  logic       thr_empty = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0;
  logic [3:0] mdelta = 4'h0;
  logic       msr_rd = 1'b0, lcr_wr = 1'b0, busy = 1'b0, usr_rd = 1'b0;
  logic       irq;
  logic [7:0] iir;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en), .ier_i(ier),
    .line_err_i(err), .lsr_rd_i(lsr_rd), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
    .rbr_rd_i(rbr_rd), .thr_empty_i(thr_empty), .thr_wr_i(thr_wr), .iir_rd_i(iir_rd),
    .modem_delta_i(mdelta), .msr_rd_i(msr_rd), .lcr_wr_i(lcr_wr),
    .uart_busy_i(busy), .usr_rd_i(usr_rd), .irq_o(irq), .iir_o(iir));

  function automatic logic [7:0] want(input logic [3:0] code, input logic fe);
    logic [7:0] v;
    v = {4'b0000, code};
    if (fe) v = v + 8'hC0;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] code);
    logic [7:0] e;
    logic ei;
    #1;
    e  = want(code, fifo_en);
    ei = (code != 4'd1);
    n_tests++;
    if (iir !== e || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", tag, iir, irq, e, ei);
    end
  endtask

  task automatic t_reset();
    check("R1 reset state", 4'd1);
  endtask

  task automatic t_line();
    ier = 8'h04;
    for (int b = 0; b < 4; b++) begin
      err = 4'h1 << b; tick(); err = 4'h0;
      check($sformatf("R4 line error bit %0d", b), 4'd6);
      lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
      check("R4 line cleared by status read", 4'd1);
    end
    ier = 8'h00;
  endtask

  task automatic t_rx();
    ier = 8'h01;
    rx_trig = 1'b1;
    check("R5 received data level", 4'd4);
    rx_trig = 1'b0;
    check("R5 level falls", 4'd1);
    rx_tmo = 1'b1; tick(); rx_tmo = 1'b0;
    check("R6 timeout held", 4'd12);
    rbr_rd = 1'b1; tick(); rbr_rd = 1'b0;
    check("R6 timeout cleared by char read", 4'd1);
    ier = 8'h00;
  endtask

  task automatic t_thre();
    ier = 8'h02;
    tick();
    thr_empty = 1'b1; tick();
    check("R7 empty rise", 4'd2);
    iir_rd = 1'b1; tick(); iir_rd = 1'b0;
    check("R7 ack by id read", 4'd1);
    thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
    check("R7 empty rise again", 4'd2);
    thr_wr = 1'b1; tick(); thr_wr = 1'b0;
    check("R7 cleared by write", 4'd1);
    ier = 8'h00; tick(); ier = 8'h02; tick();
    check("R7 enable rise while empty", 4'd2);
    ier = 8'h06;
    err = 4'h2; tick(); err = 4'h0;
    iir_rd = 1'b1; tick(); iir_rd = 1'b0;
    lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
    check("R7 read reporting other code keeps empty", 4'd2);
    thr_wr = 1'b1; tick(); thr_wr = 1'b0;
    thr_empty = 1'b0;
    ier = 8'h00; tick();
  endtask

  task automatic t_modem();
    ier = 8'h08;
    for (int b = 0; b < 4; b++) begin
      mdelta = 4'h1 << b; tick(); mdelta = 4'h0;
      check($sformatf("R8 modem change bit %0d", b), 4'd0);
      msr_rd = 1'b1; tick(); msr_rd = 1'b0;
      check("R8 modem cleared", 4'd1);
    end
    ier = 8'h00;
  endtask

  task automatic t_busy();
    lcr_wr = 1'b1; tick(); lcr_wr = 1'b0;
    check("R9 write while idle ignored", 4'd1);
    busy = 1'b1; lcr_wr = 1'b1; tick(); lcr_wr = 1'b0; busy = 1'b0;
    check("R9 busy detect without enables", 4'd7);
    rbr_rd = 1'b1; lsr_rd = 1'b1; msr_rd = 1'b1; tick();
    rbr_rd = 1'b0; lsr_rd = 1'b0; msr_rd = 1'b0;
    check("R9 other reads keep busy", 4'd7);
    usr_rd = 1'b1; tick(); usr_rd = 1'b0;
    check("R9 cleared by status read", 4'd1);
  endtask

  task automatic t_prio();
    ier = 8'h0F;
    busy = 1'b1; lcr_wr = 1'b1; mdelta = 4'h4; rx_tmo = 1'b1; err = 4'h8;
    thr_empty = 1'b1; rx_trig = 1'b1;
    tick();
    busy = 1'b0; lcr_wr = 1'b0; mdelta = 4'h0; rx_tmo = 1'b0; err = 4'h0;
    check("R10 line on top", 4'd6);
    lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
    check("R10 received data next", 4'd4);
    rx_trig = 1'b0;
    check("R10 timeout next", 4'd12);
    rbr_rd = 1'b1; tick(); rbr_rd = 1'b0;
    check("R10 transmit empty next", 4'd2);
    thr_wr = 1'b1; tick(); thr_wr = 1'b0;
    check("R10 modem next", 4'd0);
    msr_rd = 1'b1; tick(); msr_rd = 1'b0;
    check("R10 busy last", 4'd7);
    usr_rd = 1'b1; tick(); usr_rd = 1'b0;
    check("R10 all clear", 4'd1);
    thr_empty = 1'b0; ier = 8'h00; tick();
  endtask

  task automatic t_upper_ier();
    ier = 8'hF0;
    err = 4'hF; mdelta = 4'hF; rx_tmo = 1'b1; tick();
    err = 4'h0; mdelta = 4'h0; rx_tmo = 1'b0; rx_trig = 1'b1;
    check("R11 upper enables ignored", 4'd1);
    rx_trig = 1'b0;
    ier = 8'h08;
    check("R12 modem revealed on enable", 4'd0);
    ier = 8'h04;
    check("R12 line revealed on enable", 4'd6);
    ier = 8'h00;
    check("R12 disable hides without clear", 4'd1);
    ier = 8'h0D;
    check("R12 still held", 4'd6);
    lsr_rd = 1'b1; msr_rd = 1'b1; rbr_rd = 1'b1; tick();
    lsr_rd = 1'b0; msr_rd = 1'b0; rbr_rd = 1'b0;
    check("R12 cleared", 4'd1);
    ier = 8'h00;
  endtask

  task automatic t_collide();
    ier = 8'h04;
    err = 4'h1; lsr_rd = 1'b1; tick(); err = 4'h0; lsr_rd = 1'b0;
    check("R13 error beats status read", 4'd6);
    lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
    ier = 8'h00;
    busy = 1'b1; lcr_wr = 1'b1; usr_rd = 1'b1; tick();
    busy = 1'b0; lcr_wr = 1'b0; usr_rd = 1'b0;
    check("R13 busy beats status read", 4'd7);
    usr_rd = 1'b1; tick(); usr_rd = 1'b0;
    check("R13 busy then cleared", 4'd1);
  endtask

  task automatic t_fifo_bits();
    fifo_en = 1'b1;
    check("R3 fifo bits idle", 4'd1);
    ier = 8'h01; rx_trig = 1'b1;
    check("R3 fifo bits with code", 4'd4);
    rx_trig = 1'b0; ier = 8'h00;
    fifo_en = 1'b0;
    check("R2 R3 fifo bits off", 4'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_line();
    t_rx();
    t_thre();
    t_modem();
    t_busy();
    t_prio();
    t_upper_ier();
    t_collide();
    t_fifo_bits();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule